// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Carry Chaining

This block is the execute stage of a small processor datapath. Each cycle it may accept one operation: two 32-bit operands, an opcode, a request to update the status flags, and a condition field. The second operand arrives already formed. Register file, shifter and decode sit outside the block. It offers ten operations: five arithmetic (add, subtract, reverse subtract, add-with-carry, subtract-with-carry) and five bitwise (AND, OR, exclusive OR, bit clear, OR-NOT).

The block holds four status flags: negative, zero, carry and overflow. It changes them only when the caller asks. Every operation is gated by a condition evaluated from the flags as they stand before the operation. The add-with-carry and subtract-with-carry operations consume the stored carry flag. Because of this, 64-bit and wider additions and subtractions can be issued as back-to-back chained operations: the flag-setting low-word operation comes first and the carry-consuming upper-word operations follow, one per cycle, without stalls.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the result register, all four flags and `out_valid` are cleared to zero.
- R2: An executed operation writes its result to `res_q` at the rising edge where `in_valid` was high, and `out_valid` is high for the following cycle only. Opcodes: 0 ADD (a+b), 1 SUB (a-b), 2 RSB (b-a).
- R3: Opcode 3 ADC computes a+b+C and opcode 4 SBC computes a+~b+C, where C is the stored carry flag. For subtraction, carry means "no borrow", so SUB and RSB set C=1 when no borrow occurs.
- R4: Opcodes 5 AND, 6 ORR, 7 EOR, 8 BIC and 9 ORN compute a&b, a|b, a^b, a&~b and a|~b.
- R5: For an arithmetic operation with `set_flags` high, the flags are updated as follows. N is result bit 31. Z is set when the result is zero. C is the carry out of bit 31. V is the signed overflow.
- R6: For a bitwise operation with `set_flags` high, only N and Z are updated, and C and V keep their values.
- R7: With `set_flags` low, an executed operation writes its result but leaves all four flags unchanged.
- R8: The condition field `cond` is evaluated on the current flags with these codes: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always.
- R9: When the condition fails, neither `res_q` nor the flags change, even with `set_flags` high, and `out_valid` stays low.
- R10: Opcodes 10 to 15 are reserved. They write nothing and leave `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (see R2 to R4, R10) |
| set_flags | input | 1 | Update status flags with this operation |
| cond | input | 4 | Execution condition (see R8) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already formed |
| res_q | output | 32 | Registered result of the last executed operation |
| out_valid | output | 1 | High for one cycle after an executed operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Arithmetic is exercised with several operand sets. Small positive sums give all flags clear. A wrap to zero separates carry from overflow, and a positive-to-negative overflow separates overflow from carry. A subtraction with borrow checks the not-borrow sense, and a reverse subtraction confirms the operand order. Chains of two-word addition and three-word subtraction confirm that the stored carry, not a fresh constant, feeds the upper words. Bitwise operations are run with carry and overflow set beforehand, so that any disturbance of those flags shows up. Condition tests use flag states where the unsigned-higher and signed comparisons disagree with the plain zero test, and each failed condition is checked against a held result and unchanged flags.

// File: rtl/flag_alu_pkg.sv
// Shared types for the flag-setting ALU: opcodes, condition codes, flags.
// Assumes 4-bit opcode and condition fields.
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_RSB = 4'd2,
        OP_ADC = 4'd3,
        OP_SBC = 4'd4,
        OP_AND = 4'd5,
        OP_ORR = 4'd6,
        OP_EOR = 4'd7,
        OP_BIC = 4'd8,
        OP_ORN = 4'd9
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_XX = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/fa_arith.sv
// Arithmetic core: one shared adder serves ADD, SUB, RSB, ADC and SBC.
// Subtraction is done by inverting one operand and forcing or passing the
// carry-in, so carry reads as "no borrow". Purely combinational.
module fa_arith #(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         ovf,
    output logic         is_arith
);
    import flag_alu_pkg::*;

    localparam int MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic [W:0]   wide;

    // Select adder operands and carry-in for the requested operation.
    always_comb begin
        x        = a;
        y        = b;
        cin      = 1'b0;
        is_arith = 1'b1;
        case (alu_op_e'(op))
            OP_ADD: begin x = a;  y = b;  cin = 1'b0; end
            OP_SUB: begin x = a;  y = ~b; cin = 1'b1; end
            OP_RSB: begin x = b;  y = ~a; cin = 1'b1; end
            OP_ADC: begin x = a;  y = b;  cin = c_in; end
            OP_SBC: begin x = a;  y = ~b; cin = c_in; end
            default: is_arith = 1'b0;
        endcase
    end

    // Single adder with carry out and signed overflow.
    always_comb begin
        wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum   = wide[MSB:0];
        c_out = wide[W];
        ovf   = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end

endmodule

// File: rtl/fa_logic.sv
// Bitwise unit: AND, OR, XOR, AND-NOT and OR-NOT. Purely combinational.
module fa_logic #(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         is_logic
);
    import flag_alu_pkg::*;

    // Pick the bitwise function for the requested operation.
    always_comb begin
        res      = '0;
        is_logic = 1'b1;
        case (alu_op_e'(op))
            OP_AND: res = a & b;
            OP_ORR: res = a | b;
            OP_EOR: res = a ^ b;
            OP_BIC: res = a & ~b;
            OP_ORN: res = a | ~b;
            default: is_logic = 1'b0;
        endcase
    end

endmodule

// File: rtl/fa_cond.sv
// Condition evaluator: decides from the current flags whether an operation
// may execute. Codes 14 and 15 always pass. Purely combinational.
module fa_cond (
    input  logic [3:0]            cond,
    input  flag_alu_pkg::flags_t  fl,
    output logic                  pass
);
    import flag_alu_pkg::*;

    logic ge;

    // Evaluate the selected condition.
    always_comb begin
        ge = (fl.n == fl.v);
        case (cond_e'(cond))
            CC_EQ:   pass = fl.z;
            CC_NE:   pass = !fl.z;
            CC_CS:   pass = fl.c;
            CC_CC:   pass = !fl.c;
            CC_MI:   pass = fl.n;
            CC_PL:   pass = !fl.n;
            CC_VS:   pass = fl.v;
            CC_VC:   pass = !fl.v;
            CC_HI:   pass = fl.c && !fl.z;
            CC_LS:   pass = !fl.c || fl.z;
            CC_GE:   pass = ge;
            CC_LT:   pass = !ge;
            CC_GT:   pass = !fl.z && ge;
            CC_LE:   pass = fl.z || !ge;
            default: pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
// Top of the execute unit. Registers the result and the N/Z/C/V flags.
// An operation runs only if in_valid is high, the opcode is defined and
// the condition passes on the flags held before this edge. The stored
// carry feeds ADC/SBC for multiword chains. Synchronous active-low reset.
module flag_alu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op_code,
    input  logic         set_flags,
    input  logic [3:0]   cond,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] res_q,
    output logic         out_valid,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    import flag_alu_pkg::*;

    localparam int MSB = W - 1;

    flags_t       fl_q;
    logic [W-1:0] a_sum;
    logic         a_cout;
    logic         a_ovf;
    logic         is_arith;
    logic [W-1:0] l_res;
    logic         is_logic;
    logic         cond_ok;
    logic         exec;
    logic [W-1:0] nxt_res;

    fa_arith #(.W(W)) u_arith (
        .op       (op_code),
        .a        (opnd_a),
        .b        (opnd_b),
        .c_in     (fl_q.c),
        .sum      (a_sum),
        .c_out    (a_cout),
        .ovf      (a_ovf),
        .is_arith (is_arith)
    );

    fa_logic #(.W(W)) u_logic (
        .op       (op_code),
        .a        (opnd_a),
        .b        (opnd_b),
        .res      (l_res),
        .is_logic (is_logic)
    );

    fa_cond u_cond (
        .cond (cond),
        .fl   (fl_q),
        .pass (cond_ok)
    );

    // Decide whether this cycle's operation commits, and merge results.
    always_comb begin
        exec    = in_valid && cond_ok && (is_arith || is_logic);
        nxt_res = is_arith ? a_sum : l_res;
    end

    // Result and valid register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= exec;
            if (exec) res_q <= nxt_res;
        end
    end

    // Status flag register; C and V change only for arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else if (exec && set_flags) begin
            fl_q.n <= nxt_res[MSB];
            fl_q.z <= (nxt_res == '0);
            if (is_arith) begin
                fl_q.c <= a_cout;
                fl_q.v <= a_ovf;
            end
        end
    end

    assign flag_n = fl_q.n;
    assign flag_z = fl_q.z;
    assign flag_c = fl_q.c;
    assign flag_v = fl_q.v;

endmodule

// File: rtl/flag_alu_chk.sv
// Property checker for flag_alu, attached by bind. Observes ports only.
module flag_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op_code,
    input logic         set_flags,
    input logic [W-1:0] res_q,
    input logic         out_valid,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    logic is_bitop;
    assign is_bitop = (op_code >= 4'd5) && (op_code <= 4'd9);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0) && !out_valid && (res_q == '0)); // R1

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_NZ_MATCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(set_flags) |-> (flag_z == (res_q == '0)) && (flag_n == res_q[W-1])); // R5

    AST_BITOP_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_bitop |=> $stable(flag_c) && $stable(flag_v)); // R6

    AST_NO_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R7

    AST_SKIP_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(res_q)); // R9

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code >= 4'd10) |=> !out_valid); // R10

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .set_flags (set_flags),
    .res_q     (res_q),
    .out_valid (out_valid),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/sim_flag_alu.sv
// Directed bench for flag_alu: one task per scenario, each checking itself.
`timescale 1ns/1ps
module sim_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond = 4'd14;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] res_q;
    logic        out_valid;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flag_alu u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_code (op_code),
        .set_flags (set_flags), .cond (cond), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .res_q (res_q), .out_valid (out_valid), .flag_n (flag_n),
        .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation, then sample just after the committing edge.
    task automatic issue(input logic [3:0] op, input logic sf, input logic [3:0] cd,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; set_flags = sf; cond = cd;
        opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] nzcv();
        return {28'd0, flag_n, flag_z, flag_c, flag_v};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 flags", nzcv(), 32'h0);
        check("R1 result", res_q, 32'h0);
        check("R1 valid", {31'd0, out_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add_sub();
        issue(4'd0, 1'b1, 4'd14, 32'd5, 32'd7);
        check("R2 add", res_q, 32'd12);
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        check("R5 add flags", nzcv(), 32'b0000);
        @(posedge clk); #1;
        check("R2 valid one cycle", {31'd0, out_valid}, 32'd0);
        issue(4'd1, 1'b1, 4'd14, 32'd3, 32'd5);
        check("R2 sub", res_q, 32'hFFFF_FFFE);
        check("R3 sub borrow flags", nzcv(), 32'b1000);
        issue(4'd2, 1'b1, 4'd14, 32'd3, 32'd10);
        check("R2 rsb", res_q, 32'd7);
        check("R3 rsb no-borrow flags", nzcv(), 32'b0010);
        issue(4'd0, 1'b1, 4'd14, 32'h7FFF_FFFF, 32'd1);
        check("R5 overflow result", res_q, 32'h8000_0000);
        check("R5 overflow flags", nzcv(), 32'b1001);
        issue(4'd0, 1'b1, 4'd14, 32'hFFFF_FFFF, 32'd1);
        check("R5 wrap result", res_q, 32'h0);
        check("R5 wrap flags", nzcv(), 32'b0110);
    endtask

    task automatic t_chain();
        // 64-bit: 0x00000001_FFFFFFFF + 0x00000002_00000001
        issue(4'd0, 1'b1, 4'd14, 32'hFFFF_FFFF, 32'd1);
        check("R3 add64 low", res_q, 32'h0);
        issue(4'd3, 1'b0, 4'd14, 32'd1, 32'd2);
        check("R3 adc64 high", res_q, 32'd4);
        // 96-bit: {7,5,0} - {3,2,1}
        issue(4'd1, 1'b1, 4'd14, 32'd0, 32'd1);
        check("R3 sub96 low", res_q, 32'hFFFF_FFFF);
        issue(4'd4, 1'b1, 4'd14, 32'd5, 32'd2);
        check("R3 sbc96 mid", res_q, 32'd2);
        check("R3 sbc96 mid flags", nzcv(), 32'b0010);
        issue(4'd4, 1'b0, 4'd14, 32'd7, 32'd3);
        check("R3 sbc96 high", res_q, 32'd4);
    endtask

    task automatic t_logic();
        issue(4'd0, 1'b1, 4'd14, 32'h8000_0000, 32'h8000_0000);
        check("R5 c+v setup", nzcv(), 32'b0111);
        issue(4'd5, 1'b1, 4'd14, 32'h0000_FF00, 32'h0000_0F0F);
        check("R4 and", res_q, 32'h0000_0F00);
        check("R6 and keeps C V", nzcv(), 32'b0011);
        issue(4'd8, 1'b0, 4'd14, 32'h0000_00FF, 32'h0000_000F);
        check("R4 bic", res_q, 32'h0000_00F0);
        issue(4'd9, 1'b0, 4'd14, 32'h0, 32'hFFFF_0000);
        check("R4 orn", res_q, 32'h0000_FFFF);
        issue(4'd7, 1'b0, 4'd14, 32'h0000_F0F0, 32'h0000_FFFF);
        check("R4 eor", res_q, 32'h0000_0F0F);
        issue(4'd6, 1'b1, 4'd14, 32'h8000_0000, 32'd1);
        check("R4 orr", res_q, 32'h8000_0001);
        check("R6 orr flags", nzcv(), 32'b1011);
    endtask

    task automatic t_no_flags();
        issue(4'd1, 1'b1, 4'd14, 32'd9, 32'd4);
        check("R7 setup flags", nzcv(), 32'b0010);
        issue(4'd1, 1'b0, 4'd14, 32'd4, 32'd9);
        check("R7 result written", res_q, 32'hFFFF_FFFB);
        check("R7 flags held", nzcv(), 32'b0010);
    endtask

    task automatic t_cond();
        issue(4'd1, 1'b1, 4'd14, 32'd5, 32'd5);
        check("R8 setup Z C", nzcv(), 32'b0110);
        issue(4'd0, 1'b0, 4'd0, 32'd1, 32'd1);
        check("R8 EQ taken", {31'd0, out_valid}, 32'd1);
        check("R8 EQ result", res_q, 32'd2);
        issue(4'd0, 1'b1, 4'd1, 32'h7FFF_FFFF, 32'd1);
        check("R9 NE skipped", {31'd0, out_valid}, 32'd0);
        check("R9 result held", res_q, 32'd2);
        check("R9 flags held", nzcv(), 32'b0110);
        issue(4'd0, 1'b0, 4'd8, 32'd3, 32'd3);
        check("R8 HI fails on Z", res_q, 32'd2);
        issue(4'd0, 1'b0, 4'd9, 32'd3, 32'd3);
        check("R8 LS taken", res_q, 32'd6);
        issue(4'd1, 1'b1, 4'd14, 32'd6, 32'd5);
        issue(4'd0, 1'b0, 4'd8, 32'd10, 32'd0);
        check("R8 HI taken", res_q, 32'd10);
        issue(4'd0, 1'b0, 4'd11, 32'd20, 32'd0);
        check("R8 LT fails", res_q, 32'd10);
        issue(4'd0, 1'b0, 4'd12, 32'd30, 32'd0);
        check("R8 GT taken", res_q, 32'd30);
        issue(4'd0, 1'b1, 4'd14, 32'h7FFF_FFFF, 32'd1);
        issue(4'd0, 1'b0, 4'd10, 32'd40, 32'd0);
        check("R8 GE with N=V=1", res_q, 32'd40);
        issue(4'd0, 1'b0, 4'd3, 32'd50, 32'd0);
        check("R8 CC taken", res_q, 32'd50);
    endtask

    task automatic t_reserved();
        issue(4'd0, 1'b1, 4'd14, 32'd1, 32'd2);
        issue(4'd12, 1'b1, 4'd14, 32'd0, 32'd0);
        check("R10 no valid", {31'd0, out_valid}, 32'd0);
        check("R10 result held", res_q, 32'd3);
        check("R10 flags held", nzcv(), 32'b0000);
        issue(4'd15, 1'b1, 4'd14, 32'hFFFF_FFFF, 32'd1);
        check("R10 op15 held", res_q, 32'd3);
    endtask

    initial begin
        t_reset();
        t_add_sub();
        t_chain();
        t_logic();
        t_no_flags();
        t_cond();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule